// File: doc/BRIEF.md
# Frame-Synchronized Serial Transmit Buffer

This block is the transmit half of a frame-synchronized serial port. A host loads a word through a two-half holding register: an optional high half (bits above 16) and a low half. A write to the low half commits the whole word. When the shifter is idle, both halves are copied into a staging register. Each frame-sync pulse then loads the staged word into a shift register. The shift register drives it onto a single data line, most significant bit first, one bit per clock.

The block shows how the buffer is doing through two flags. A ready flag shows that the holding register may be written. An active-low empty flag drops when the staged word has been sent and nothing new has arrived. If the host falls behind, every later frame sends the last staged word again. If no word was ever staged after reset, the frame carries zeros. In self-sync mode the block makes its own one-cycle frame pulse for every copy into the staging register, and the external sync input is ignored.

Top module: `ser_tx_buffer`

## Requirements
- R1: While reset is held and on the first cycles after it, tx_ready is 1, tx_empty_n is 0, dx is 0 and fs_out is 0.
- R2: A low-half write in an idle cycle with no sync starting is copied to the staging register at that clock edge. From the next cycle tx_ready and tx_empty_n are both 1, so the word is ready before the first sync.
- R3: When a frame starts at a clock edge (fs_in sampled high in external mode), dx carries the staged WORD_W-bit word MSB first over the next WORD_W cycles. dx is 0 whenever no frame is in progress.
- R4: A frame that starts before any word has been staged since reset sends all zeros, and tx_empty_n stays 0.
- R5: With no new low-half write, every later frame sends the previously staged word again.
- R6: The staged word is {high half, low half}, with the high half in bits WORD_W-1:16. The high half is written through wr_data[WORD_W-17:0] with wr_hi. If the high half is not written again before a low-half write, its previous value is staged unchanged.
- R7: A low-half write during a frame drops tx_ready to 0. The frame in progress is unaffected. The copy happens on the first idle clock edge after the frame, which sets tx_ready and tx_empty_n to 1, and the next frame carries the new word.
- R8: With self_fs_en = 1, each copy gives exactly one fs_out pulse, in the cycle after the copy, and that pulse starts the frame. fs_in is ignored in this mode. With self_fs_en = 0, fs_out stays 0.
- R9: tx_empty_n drops to 0 at the clock edge that ends a frame.
- R10: fs_in pulses during a frame in progress are ignored. The frame keeps its length and content, and no new frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| self_fs_en | input | 1 | 1: the block makes its own frame pulse on each copy; 0: it uses fs_in |
| fs_in | input | 1 | External frame-sync pulse |
| wr_hi | input | 1 | Write strobe for the high half of the holding register |
| wr_lo | input | 1 | Write strobe for the low half; commits the whole word |
| wr_data | input | 16 | Write data for either half |
| dx | output | 1 | Serial data out, MSB first |
| fs_out | output | 1 | Self-generated frame pulse |
| tx_ready | output | 1 | Holding register may be written |
| tx_empty_n | output | 1 | Active-low empty flag: 0 means underflow or nothing staged |

## Verification
The bench builds the block with WORD_W = 24, so a high half of 8 bits exists and the carry-over of an unrefreshed high half shows in the serial stream. With this width a frame lasts 24 cycles. That leaves room for directed low-half writes and stray sync pulses at chosen bit positions inside a frame. Random sequences of half writes and frames are compared against a bench model of the holding and staging registers.

// File: rtl/stb_pkg.sv
package stb_pkg;

  function automatic int lo_width(input int word_w);
    return (word_w > 16) ? 16 : word_w;
  endfunction

  function automatic int hi_width(input int word_w);
    return (word_w > 16) ? (word_w - 16) : 1;
  endfunction

endpackage

// File: rtl/stb_hold.sv
module stb_hold #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [15:0]       wr_data,
  input  logic              copy,
  output logic [WORD_W-1:0] word,
  output logic              pending,
  output logic              ready
);
  localparam int LO_W = stb_pkg::lo_width(WORD_W);
  localparam int HI_W = stb_pkg::hi_width(WORD_W);

  logic [LO_W-1:0] lo_q, lo_d, lo_src;
  logic            pend_d, rdy_d;

  // a low write presents its data directly so a same-cycle copy sees it
  assign lo_src = wr_lo ? wr_data[LO_W-1:0] : lo_q;

  always_comb begin
    lo_d   = lo_q;
    pend_d = pending;
    rdy_d  = ready;
    if (wr_lo) begin
      lo_d   = wr_data[LO_W-1:0];
      pend_d = 1'b1;
      rdy_d  = 1'b0;
    end
    if (copy) begin
      pend_d = 1'b0;
      rdy_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= '0;
      pending <= 1'b0;
      ready   <= 1'b1;
    end else begin
      lo_q    <= lo_d;
      pending <= pend_d;
      ready   <= rdy_d;
    end
  end

  generate
    if (WORD_W > 16) begin : g_hi
      logic [HI_W-1:0] hi_q, hi_d;
      always_comb begin
        hi_d = hi_q;
        if (wr_hi) hi_d = wr_data[HI_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_q <= '0;
        else        hi_q <= hi_d;
      end
      assign word = {hi_q, lo_src};
    end else begin : g_lo_only
      assign word = lo_src;
    end
  endgenerate

  AST_READY_ON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> ready); // R2
  AST_LO_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !copy) |=> !ready); // R7
  AST_READY_VS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    ready != pending); // R7

endmodule

// File: rtl/stb_stage.sv
module stb_stage #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              copy,
  input  logic [WORD_W-1:0] word,
  input  logic              frame_end,
  input  logic              self_fs_en,
  output logic [WORD_W-1:0] frame_word,
  output logic              empty_n,
  output logic              fs_gen
);
  logic [WORD_W-1:0] stage_q, stage_d;
  logic              loaded_q, loaded_d;
  logic              empty_d, fsg_d;

  always_comb begin
    stage_d  = stage_q;
    loaded_d = loaded_q;
    empty_d  = empty_n;
    fsg_d    = 1'b0;
    if (frame_end) empty_d = 1'b0;
    if (copy) begin
      stage_d  = word;
      loaded_d = 1'b1;
      empty_d  = 1'b1;
      fsg_d    = self_fs_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      loaded_q <= 1'b0;
      empty_n  <= 1'b0;
      fs_gen   <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      loaded_q <= loaded_d;
      empty_n  <= empty_d;
      fs_gen   <= fsg_d;
    end
  end

  // nothing staged since reset: frames carry zeros
  assign frame_word = loaded_q ? stage_q : '0;

  AST_EMPTY_ON_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    copy |=> empty_n); // R2
  AST_UNLOADED_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !loaded_q |-> !empty_n); // R4

endmodule

// File: rtl/stb_shift.sv
module stb_shift #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [WORD_W-1:0] frame_word,
  output logic              dx,
  output logic              busy,
  output logic              frame_end
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy_d;

  assign frame_end = busy && (cnt_q == '0);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    busy_d = busy;
    if (frame_start) begin
      sh_d   = frame_word;
      cnt_d  = CNT_TOP;
      busy_d = 1'b1;
    end else if (busy) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      busy  <= busy_d;
    end
  end

  assign dx = busy & sh_q[WORD_W-1];

  AST_FIRST_BIT_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (dx == $past(frame_word[WORD_W-1]))); // R3
  AST_FRAME_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> busy); // R10

endmodule

// File: rtl/ser_tx_buffer.sv
module ser_tx_buffer #(
  parameter int WORD_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        self_fs_en,
  input  logic        fs_in,
  input  logic        wr_hi,
  input  logic        wr_lo,
  input  logic [15:0] wr_data,
  output logic        dx,
  output logic        fs_out,
  output logic        tx_ready,
  output logic        tx_empty_n
);
  logic              rst_meta, rst_q;
  logic              copy, pending, busy, frame_end, frame_start, fs_gen, sync_sel;
  logic [WORD_W-1:0] hold_word, frame_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  assign sync_sel    = self_fs_en ? fs_gen : fs_in;
  assign frame_start = sync_sel && !busy;
  assign copy        = (wr_lo || pending) && !busy && !frame_start;
  assign fs_out      = fs_gen;

  stb_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_q), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .copy(copy), .word(hold_word), .pending(pending), .ready(tx_ready)
  );

  stb_stage #(.WORD_W(WORD_W)) u_stage (
    .clk(clk), .rst_n(rst_q), .copy(copy), .word(hold_word),
    .frame_end(frame_end), .self_fs_en(self_fs_en),
    .frame_word(frame_word), .empty_n(tx_empty_n), .fs_gen(fs_gen)
  );

  stb_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .frame_start(frame_start), .frame_word(frame_word),
    .dx(dx), .busy(busy), .frame_end(frame_end)
  );

  AST_SELF_PULSE_STARTS: assert property (@(posedge clk) disable iff (!rst_q)
    fs_out |=> busy); // R8

endmodule

// File: tb/sim_ser_tx_buffer.sv
module sim_ser_tx_buffer;
  localparam int W = 24;

  logic clk = 1'b0;
  logic rst_n, self_fs_en, fs_in, wr_hi, wr_lo;
  logic [15:0] wr_data;
  logic dx, fs_out, tx_ready, tx_empty_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [7:0]   hi_m;
  logic [W-1:0] stage_m;
  bit           loaded_m;

  always #5 clk = ~clk;

  ser_tx_buffer #(.WORD_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .self_fs_en(self_fs_en), .fs_in(fs_in),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .dx(dx), .fs_out(fs_out), .tx_ready(tx_ready), .tx_empty_n(tx_empty_n)
  );

  function automatic logic [W-1:0] exp_frame();
    return loaded_m ? stage_m : '0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_hi(input logic [7:0] d);
    wr_hi = 1'b1; wr_data = {8'h00, d};
    tick();
    wr_hi = 1'b0;
    hi_m = d;
  endtask

  task automatic write_lo(input logic [15:0] d);
    wr_lo = 1'b1; wr_data = d;
    tick();
    wr_lo = 1'b0;
    stage_m = {hi_m, d};
    loaded_m = 1'b1;
  endtask

  // external frame; optional low write at bit inj_at, optional stray sync at bit fs_at
  task automatic run_frame(input int inj_at, input logic [15:0] inj_d, input int fs_at,
                           output logic [W-1:0] got);
    got = '0;
    fs_in = 1'b1;
    tick();
    fs_in = 1'b0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], dx};
      if (i == inj_at) begin wr_lo = 1'b1; wr_data = inj_d; end
      if (i == fs_at) fs_in = 1'b1;
      tick();
      wr_lo = 1'b0; fs_in = 1'b0;
      if (i == inj_at) chk(tx_ready == 1'b0, "R7 ready low after mid-frame write", 32'(tx_ready), 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got, e;
    int ones;
    void'($urandom(32'd7741));
    rst_n = 1'b0; self_fs_en = 1'b0; fs_in = 1'b0;
    wr_hi = 1'b0; wr_lo = 1'b0; wr_data = '0;
    hi_m = '0; stage_m = '0; loaded_m = 1'b0;
    tick(); tick();
    chk(tx_ready == 1'b1, "R1 ready in reset", 32'(tx_ready), 1);
    chk(tx_empty_n == 1'b0, "R1 empty_n in reset", 32'(tx_empty_n), 0);
    chk(dx == 1'b0 && fs_out == 1'b0, "R1 dx/fs_out in reset", {30'd0, dx, fs_out}, 0);
    rst_n = 1'b1;
    tick(); tick(); tick();
    chk(tx_ready == 1'b1 && tx_empty_n == 1'b0, "R1 flags after release",
        {30'd0, tx_ready, tx_empty_n}, 32'h2);

    // R4: sync before any load sends zeros
    run_frame(-1, '0, -1, got);
    chk(got == '0, "R4 zeros before first load", 32'(got), 0);
    chk(tx_empty_n == 1'b0, "R4 empty stays low", 32'(tx_empty_n), 0);

    // R2, R6: write before sync, both halves
    write_hi(8'hA5);
    write_lo(16'h1234);
    chk(tx_ready == 1'b1 && tx_empty_n == 1'b1, "R2 flags after idle write",
        {30'd0, tx_ready, tx_empty_n}, 32'h3);
    chk(fs_out == 1'b0, "R8 no pulse in external mode", 32'(fs_out), 0);
    e = exp_frame();
    run_frame(-1, '0, -1, got);
    chk(got == e, "R3 R6 first frame word", 32'(got), 32'(e));
    chk(tx_empty_n == 1'b0, "R9 empty drops at frame end", 32'(tx_empty_n), 0);
    chk(dx == 1'b0, "R3 dx idle after frame", 32'(dx), 0);

    // R5: repeated underflow frames
    for (int k = 0; k < 3; k++) begin
      run_frame(-1, '0, -1, got);
      chk(got == 24'hA51234, "R5 resend on underflow", 32'(got), 32'hA51234);
    end

    // R6: low write without refreshing high half
    write_lo(16'h5678);
    e = exp_frame();
    run_frame(-1, '0, -1, got);
    chk(got == 24'hA55678 && got == e, "R6 stale high half", 32'(got), 32'hA55678);

    // R7: low write during a frame
    run_frame(5, 16'h0F0F, -1, got);
    chk(got == 24'hA55678, "R7 frame unaffected by write", 32'(got), 32'hA55678);
    chk(tx_ready == 1'b0, "R7 ready low at frame end", 32'(tx_ready), 0);
    tick();
    stage_m = {hi_m, 16'h0F0F};
    chk(tx_ready == 1'b1 && tx_empty_n == 1'b1, "R7 copy after frame",
        {30'd0, tx_ready, tx_empty_n}, 32'h3);
    run_frame(-1, '0, -1, got);
    chk(got == 24'hA50F0F, "R7 next frame carries new word", 32'(got), 32'hA50F0F);

    // R10: stray sync during frame
    run_frame(-1, '0, 3, got);
    chk(got == 24'hA50F0F, "R10 frame kept under stray sync", 32'(got), 32'hA50F0F);
    chk(dx == 1'b0, "R10 no restart after stray sync", 32'(dx), 0);
    tick();
    chk(dx == 1'b0, "R10 line stays idle", 32'(dx), 0);

    // R8: self-sync mode
    self_fs_en = 1'b1;
    fs_in = 1'b1; tick(); fs_in = 1'b0;
    chk(dx == 1'b0, "R8 fs_in ignored in self mode", 32'(dx), 0);
    tick();
    chk(dx == 1'b0, "R8 fs_in ignored in self mode, later", 32'(dx), 0);
    write_hi(8'h3C);
    chk(fs_out == 1'b0, "R8 no pulse on high write", 32'(fs_out), 0);
    write_lo(16'hC3E1);
    chk(fs_out == 1'b1, "R8 pulse after copy", 32'(fs_out), 1);
    tick();
    ones = 0;
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], dx};
      if (fs_out) ones++;
      tick();
    end
    chk(got == 24'h3CC3E1, "R8 self-started frame", 32'(got), 32'h3CC3E1);
    for (int i = 0; i < 4; i++) begin
      if (fs_out) ones++;
      tick();
    end
    chk(ones == 0, "R8 exactly one pulse", 32'(ones), 0);
    self_fs_en = 1'b0;

    // random mix, external mode
    for (int n = 0; n < 60; n++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        write_hi(8'($urandom));
      end else if (op == 1) begin
        write_lo(16'($urandom));
        chk(tx_empty_n == 1'b1, "R2 random write empty_n", 32'(tx_empty_n), 1);
      end else begin
        e = exp_frame();
        run_frame(-1, '0, -1, got);
        chk(got == e, "R5 R6 random frame", 32'(got), 32'(e));
        chk(tx_empty_n == 1'b0, "R9 random frame end", 32'(tx_empty_n), 0);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule